// File: doc/BRIEF.md
# Watchdog Timer with Reset-Cause Status Flags

This block is a free-running watchdog counter paired with two status flags. Together the flags record what caused the most recent reset or wake-up. The time-out flag (T) drops to 0 only when the watchdog expires. The power-down flag (P) drops to 0 when the part enters sleep. Software reads the pair after restart to tell apart four cases: a power-up, a watchdog reset while running, a watchdog wake from sleep, and a reset-pin wake from sleep.

The counter advances on a slow tick input while the enable input is high. A clear-watchdog command restarts it, and so does the sleep command. When the counter expires, the block emits one single-cycle pulse. If the part is asleep, the pulse is a wake request. If the part is running, the pulse is a reset request.

The block also holds the sleep indicator. The sleep command sets it. Any wake, by the watchdog or by the reset pin, clears it. A low level on the reset pin while the part is running restarts the counter and leaves both flags as they were.

Top module: `wdog_flags`

## Requirements
- R1: While the power-on reset input `por_n` is low, and afterwards until another event occurs, the block holds T=1, P=1 and asleep=0, and both pulse outputs stay low.
- R2: The counter has CNT_W bits and starts at 0. It advances only on cycles where `tick` and `wdt_en` are both 1. Expiry happens on the 2^CNT_W-th such cycle after a restart, which is the 256th with the default width. Ticks taken while `wdt_en` is 0 do not advance it.
- R3: An expiry while asleep=0 produces `wdt_reset`=1 for exactly one cycle, starting in the cycle after the expiring tick. In that same cycle it leaves T=0 and P=1.
- R4: An expiry while asleep=1 produces `wdt_wake`=1 for exactly one cycle, starting in the cycle after the expiring tick. In that same cycle it leaves T=0, P=0 and asleep=0.
- R5: A `clr_cmd` pulse while running sets T=1 and P=1 and restarts the counter.
- R6: A `sleep_cmd` pulse while running sets T=1, P=0 and asleep=1, and restarts the counter.
- R7: A low level on `rst_pin_n` restarts the counter. If the part is asleep, it also sets T=1, P=0 and asleep=0. If the part is running, T and P keep their values.
- R8: While asleep=1, both `clr_cmd` and `sleep_cmd` are ignored: they change neither the flags nor the counter.
- R9: A command or reset-pin event takes precedence over an expiring tick in the same cycle. No pulse is produced and the counter restarts from 0.
- R10: `wdt_reset` and `wdt_wake` are never high together, and neither stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_pin_n | input | 1 | External reset pin, active low, sampled on clk |
| tick | input | 1 | Single-cycle strobe from the slow time base |
| wdt_en | input | 1 | Watchdog count enable |
| clr_cmd | input | 1 | Clear-watchdog command strobe |
| sleep_cmd | input | 1 | Enter-sleep command strobe |
| wdt_reset | output | 1 | One-cycle reset request on expiry while running |
| wdt_wake | output | 1 | One-cycle wake request on expiry while asleep |
| asleep | output | 1 | Sleep indicator |
| flag_to | output | 1 | Time-out flag T |
| flag_pd | output | 1 | Power-down flag P |

## Verification
The counter is driven with continuous ticks, with ticks while disabled, and with ticks that are interrupted by a command or a reset-pin pulse partway through the count. Shifting the pulse position in these cases separates a counter that restarts correctly from one that merely pauses. Every one of the four flag encodings is reached from a different prior state. A running reset-pin pulse is applied while P=0, so "unchanged" cannot be confused with the power-up value. Commands issued during sleep, and a command that coincides with an expiring tick, test the ignore rule and the priority rule.

// File: rtl/wdog_flags.sv
module wdog_flags #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_pin_n,
  input  logic tick,
  input  logic wdt_en,
  input  logic clr_cmd,
  input  logic sleep_cmd,
  output logic wdt_reset,
  output logic wdt_wake,
  output logic asleep,
  output logic flag_to,
  output logic flag_pd
);

  localparam logic [CNT_W-1:0] TERM = '1;

  logic [CNT_W-1:0] cnt;

  wire pin_hit = ~rst_pin_n;
  wire do_sleep = ~asleep & sleep_cmd;
  wire do_clr = ~asleep & clr_cmd & ~sleep_cmd;
  wire advance = wdt_en & tick;
  wire expire = advance & (cnt == TERM) & ~pin_hit & ~do_sleep & ~do_clr;
  wire restart = pin_hit | do_sleep | do_clr;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= '0;
    end else if (advance) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      flag_to <= 1'b1;
      flag_pd <= 1'b1;
      asleep  <= 1'b0;
    end else if (pin_hit) begin
      if (asleep) begin
        flag_to <= 1'b1;
        flag_pd <= 1'b0;
        asleep  <= 1'b0;
      end
    end else if (do_sleep) begin
      flag_to <= 1'b1;
      flag_pd <= 1'b0;
      asleep  <= 1'b1;
    end else if (do_clr) begin
      flag_to <= 1'b1;
      flag_pd <= 1'b1;
    end else if (expire) begin
      flag_to <= 1'b0;
      flag_pd <= ~asleep;
      asleep  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      wdt_reset <= 1'b0;
      wdt_wake  <= 1'b0;
    end else begin
      wdt_reset <= expire & ~asleep;
      wdt_wake  <= expire & asleep;
    end
  end

endmodule

// File: rtl/wdog_flags_sva.sv
module wdog_flags_sva (
  input logic clk,
  input logic por_n,
  input logic rst_pin_n,
  input logic clr_cmd,
  input logic sleep_cmd,
  input logic wdt_reset,
  input logic wdt_wake,
  input logic asleep,
  input logic flag_to,
  input logic flag_pd
);

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!por_n)
    !(wdt_reset && wdt_wake)); // R10

  AST_RESET_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
    wdt_reset |=> !wdt_reset); // R10

  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
    wdt_wake |=> !wdt_wake); // R10

  AST_RESET_FLAGS: assert property (@(posedge clk) disable iff (!por_n)
    wdt_reset |-> (!flag_to && flag_pd && !asleep)); // R3

  AST_WAKE_FLAGS: assert property (@(posedge clk) disable iff (!por_n)
    wdt_wake |-> (!flag_to && !flag_pd && !asleep)); // R4

  AST_WAKE_FROM_SLEEP: assert property (@(posedge clk) disable iff (!por_n)
    $rose(wdt_wake) |-> $past(asleep)); // R4

  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!por_n)
    $rose(asleep) |-> (flag_to && !flag_pd)); // R6

  AST_PIN_RUNNING: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_pin_n && !asleep) |=> ($stable(flag_to) && $stable(flag_pd) && !wdt_reset)); // R7

  AST_CMD_IN_SLEEP: assert property (@(posedge clk) disable iff (!por_n)
    (asleep && rst_pin_n && (clr_cmd || sleep_cmd)) |=> (!flag_pd && (asleep || wdt_wake))); // R8

endmodule

bind wdog_flags wdog_flags_sva u_sva (
  .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .clr_cmd(clr_cmd),
  .sleep_cmd(sleep_cmd), .wdt_reset(wdt_reset), .wdt_wake(wdt_wake),
  .asleep(asleep), .flag_to(flag_to), .flag_pd(flag_pd)
);

// File: tb/wdog_flags_test.sv
module wdog_flags_test;
  logic clk = 1'b0;
  logic por_n = 1'b0, rst_pin_n = 1'b1, tick = 1'b0, wdt_en = 1'b0;
  logic clr_cmd = 1'b0, sleep_cmd = 1'b0;
  logic wdt_reset, wdt_wake, asleep, flag_to, flag_pd;

  always #2.5 clk = ~clk;

  wdog_flags #(.CNT_W(8)) uut (
    .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .tick(tick), .wdt_en(wdt_en),
    .clr_cmd(clr_cmd), .sleep_cmd(sleep_cmd), .wdt_reset(wdt_reset), .wdt_wake(wdt_wake),
    .asleep(asleep), .flag_to(flag_to), .flag_pd(flag_pd)
  );

  int checks = 0, fails = 0, n_rst = 0, n_wake = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  int m_cnt = 0;
  bit m_t = 1, m_p = 1, m_sl = 0, m_rp = 0, m_wk = 0;

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_cnt = 0; m_t = 1; m_p = 1; m_sl = 0; m_rp = 0; m_wk = 0;
    end else begin
      m_rp = 0; m_wk = 0;
      if (!rst_pin_n) begin
        m_cnt = 0;
        if (m_sl) begin m_t = 1; m_p = 0; m_sl = 0; end
      end else if (!m_sl && sleep_cmd) begin
        m_cnt = 0; m_t = 1; m_p = 0; m_sl = 1;
      end else if (!m_sl && clr_cmd) begin
        m_cnt = 0; m_t = 1; m_p = 1;
      end else if (wdt_en && tick) begin
        m_cnt = m_cnt + 1;
        if (m_cnt == 256) begin
          m_cnt = 0; m_t = 0;
          if (m_sl) begin m_wk = 1; m_p = 0; m_sl = 0; end
          else begin m_rp = 1; m_p = 1; end
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(cur_req, "flag_to", flag_to, m_t);
      chk(cur_req, "flag_pd", flag_pd, m_p);
      chk(cur_req, "asleep", asleep, m_sl);
      chk("R10", "wdt_reset", wdt_reset, m_rp);
      chk("R10", "wdt_wake", wdt_wake, m_wk);
      if (wdt_reset) n_rst++;
      if (wdt_wake) n_wake++;
    end
  endtask

  task automatic pulse_clr();  clr_cmd = 1;   cyc(1); clr_cmd = 0;   endtask
  task automatic pulse_slp();  sleep_cmd = 1; cyc(1); sleep_cmd = 0; endtask
  task automatic pulse_pin();  rst_pin_n = 0; cyc(1); rst_pin_n = 1; endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    cur_req = "R1";
    cyc(3);
    chk("R1", "T in reset", flag_to, 1);
    chk("R1", "P in reset", flag_pd, 1);
    chk("R1", "asleep in reset", asleep, 0);
    por_n = 1;
    cyc(2);
    chk("R1", "T after reset", flag_to, 1);

    cur_req = "R3";
    wdt_en = 1; tick = 1;
    cyc(255);
    chk("R2", "no reset before 256 ticks", n_rst, 0);
    cyc(1);
    chk("R3", "reset pulse after 256 ticks", n_rst, 1);
    chk("R3", "T after running expiry", flag_to, 0);
    chk("R3", "P after running expiry", flag_pd, 1);
    cyc(50);
    chk("R10", "single reset pulse", n_rst, 1);

    cur_req = "R5"; tick = 0;
    pulse_clr();
    chk("R5", "T after clear", flag_to, 1);
    chk("R5", "P after clear", flag_pd, 1);

    cur_req = "R2"; wdt_en = 0; tick = 1;
    cyc(300);
    chk("R2", "disabled ticks ignored", n_rst, 1);
    tick = 0; wdt_en = 1;

    cur_req = "R6";
    pulse_slp();
    chk("R6", "asleep after sleep", asleep, 1);
    chk("R6", "P after sleep", flag_pd, 0);
    chk("R6", "T after sleep", flag_to, 1);

    cur_req = "R8";
    pulse_clr();
    chk("R8", "clear ignored asleep P", flag_pd, 0);
    chk("R8", "clear ignored asleep state", asleep, 1);
    tick = 1; cyc(100); tick = 0;
    pulse_clr();
    pulse_slp();
    cur_req = "R4"; tick = 1;
    cyc(155);
    chk("R8", "commands did not restart count", n_wake, 0);
    cyc(1);
    chk("R4", "wake pulse", n_wake, 1);
    chk("R4", "T after wake", flag_to, 0);
    chk("R4", "P after wake", flag_pd, 0);
    chk("R4", "asleep after wake", asleep, 0);
    chk("R10", "wake did not reset", n_rst, 1);
    tick = 0;

    cur_req = "R7";
    pulse_slp();
    tick = 1; cyc(40); tick = 0;
    pulse_pin();
    chk("R7", "pin wake asleep", asleep, 0);
    chk("R7", "pin wake T", flag_to, 1);
    chk("R7", "pin wake P", flag_pd, 0);
    tick = 1; cyc(200); tick = 0;
    pulse_pin();
    chk("R7", "running pin keeps T", flag_to, 1);
    chk("R7", "running pin keeps P", flag_pd, 0);
    tick = 1; cyc(255);
    chk("R7", "pin restarted count", n_rst, 1);
    cyc(1);
    chk("R7", "expiry after pin restart", n_rst, 2);
    tick = 0;

    cur_req = "R9";
    pulse_clr();
    tick = 1; cyc(255);
    clr_cmd = 1; cyc(1); clr_cmd = 0;
    cyc(255);
    chk("R9", "clear beats expiring tick", n_rst, 2);
    cyc(1);
    chk("R9", "count restarted at clear", n_rst, 3);
    tick = 0;

    cur_req = "R1";
    cyc(5);
    por_n = 0; cyc(2);
    chk("R1", "T after second power-up", flag_to, 1);
    chk("R1", "P after second power-up", flag_pd, 1);
    por_n = 1; cyc(3);

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end
endmodule